// File: doc/BRIEF.md
# Dual-Address Synchronous SRAM with Pass-Through

This block is a synchronous word memory with two fully independent access ports, called X and Y. Each port carries its own address, write data, a pair of select lines, a write strobe, a forwarding control and an output enable. In any clock cycle each port may read the array, write it, or forward its own write-data input straight to the opposite port's output. It suits shared packet or cell buffers, where one agent fills the memory while another drains it, and data can sometimes bypass the array altogether.

All controls and data are registered on the rising clock edge. The array access happens on the next edge, which also loads a per-port output register and a per-port valid flag. The output enables are not registered: they gate the output register onto the port at once. The word is 36 bits wide and is stored as four 9-bit lanes. The depth is set by the address-width parameter. When both ports touch the same address in one cycle, fixed rules decide the result: a read sees the old word, and when both ports write, the Y port wins.

Top module: `dual_addr_sram`

## Requirements
- R1: A write on one port followed by a read of the same address on either port returns all 36 bits unchanged. Read data and the valid flag (1 = loaded) appear at the second rising edge after the inputs are presented. After only the first edge the valid flag is still 0.
- R2: A port acts only when its active-low select is 0 and its active-high select is 1. Otherwise a write stores nothing, and a read leaves the valid flag at 0 and the output register unchanged. A write cycle also leaves the valid flag at 0 and the output register unchanged.
- R3: The output enable (active low) works without a clock. While it is 1, the drive flag is 0 and the read-data output is all zeros. While it is 0, the drive flag is 1 and the output shows the output register.
- R4: A port whose forwarding control is 0 while it is selected loads its write-data input into the other port's output register and sets that port's valid flag. On the receiving port this replaces any read. Forwarding works in both directions in the same cycle.
- R5: When both ports read the same address in one cycle, both return the stored word.
- R6: When one port writes an address and the other reads that address in the same cycle, the read returns the word stored before the write, and the new word is stored afterwards.
- R7: When both ports write the same address in one cycle, the word from port Y is stored.
- R8: A port that writes while the other port forwards to it still performs its array write. Only its output shows the forwarded word.
- R9: The first rising edge after reset is released is ignored. A write presented then stores nothing, and a read presented then leaves the valid flag at 0.
- R10: While reset (synchronous, active low) is applied, both valid flags and both output registers are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_addr | input | ADDR_W | Port X address |
| x_wdata | input | 36 | Port X write / forward data |
| x_en_n | input | 1 | Port X select, active low |
| x_en | input | 1 | Port X select, active high |
| x_wr_n | input | 1 | Port X write strobe, active low (1 = read) |
| x_pass_n | input | 1 | Port X forward-to-Y control, active low |
| x_oe_n | input | 1 | Port X output enable, active low, unclocked |
| x_rdata | output | 36 | Port X read data (zero when not enabled) |
| x_drive | output | 1 | Port X bus-drive flag |
| x_valid | output | 1 | Port X output register loaded last edge |
| y_addr | input | ADDR_W | Port Y address |
| y_wdata | input | 36 | Port Y write / forward data |
| y_en_n | input | 1 | Port Y select, active low |
| y_en | input | 1 | Port Y select, active high |
| y_wr_n | input | 1 | Port Y write strobe, active low (1 = read) |
| y_pass_n | input | 1 | Port Y forward-to-X control, active low |
| y_oe_n | input | 1 | Port Y output enable, active low, unclocked |
| y_rdata | output | 36 | Port Y read data (zero when not enabled) |
| y_drive | output | 1 | Port Y bus-drive flag |
| y_valid | output | 1 | Port Y output register loaded last edge |

## Verification
Internal state can go wrong in three places: a captured operation bit, a lane write, or the start-up qualifier. A wrong operation bit shows at the ports two edges after the inputs as a wrong valid flag or a wrong output word. A wrong lane write stays hidden until a later read of that address, so every collision and forwarding case is followed by a read-back of the affected word. The ignored first cycle is checked by storing a known word before a second reset and then trying to overwrite it on the first edge after release.

// File: rtl/dsram_pkg.sv
// Package: shared types for the dual-address SRAM.
// Assumes: nothing beyond standard SystemVerilog.
package dsram_pkg;
    // Registered operation bits of one port for one cycle.
    typedef struct packed {
        logic rd;
        logic wr;
        logic fwd;
    } port_op_t;
endpackage

// File: rtl/dsram_in_stage.sv
// Module: input capture register for one port.
// Decodes the select pair, the write strobe and the forward control into
// operation bits and registers them with the address and write data.
// Assumes: `armed` is low on the first edge after reset, which suppresses
// every operation captured on that edge.
module dsram_in_stage
    import dsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en_n_i,
    input  logic              en_i,
    input  logic              wr_n_i,
    input  logic              pass_n_i,
    output port_op_t          op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic act;

    assign act = armed & ~en_n_i & en_i;

    // Capture the qualified operation bits; they are cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_o <= '0;
        end else begin
            op_o.rd  <= act & wr_n_i;
            op_o.wr  <= act & ~wr_n_i;
            op_o.fwd <= act & ~pass_n_i;
        end
    end

    // Capture address and data every edge; they only matter when an op bit is set.
    always_ff @(posedge clk) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
    end
endmodule

// File: rtl/dsram_lane.sv
// Module: one 9-bit-wide slice of the storage array, with two write ports
// and two combinational read ports.
// A read sees the contents from before this edge's writes, because the
// reads are combinational and the writes take effect at the edge.
// When both ports write the same address, port Y's data is stored.
// Assumes: the caller registers addresses and write enables.
module dsram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              x_we,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [LANE_W-1:0] x_wd,
    input  logic              y_we,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [LANE_W-1:0] y_wd,
    output logic [LANE_W-1:0] x_rd,
    output logic [LANE_W-1:0] y_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic              x_blocked;

    assign x_blocked = y_we && (y_addr == x_addr);

    // Store the lane; port Y takes priority on a shared address.
    always_ff @(posedge clk) begin
        if (x_we && !x_blocked) begin
            mem[x_addr] <= x_wd;
        end
        if (y_we) begin
            mem[y_addr] <= y_wd;
        end
    end

    assign x_rd = mem[x_addr];
    assign y_rd = mem[y_addr];
endmodule

// File: rtl/dsram_out_stage.sv
// Module: output register and output-enable gate for one port.
// Loads forwarded data in preference to array data, and flags each load.
// Assumes: fwd_en comes from the opposite port's capture stage.
module dsram_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              fwd_en,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              drive,
    output logic              valid
);
    logic [DATA_W-1:0] q;

    // Load forwarded or array data; hold the word and clear valid otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            valid <= 1'b0;
        end else if (fwd_en) begin
            q     <= fwd_data;
            valid <= 1'b1;
        end else if (rd_en) begin
            q     <= rd_data;
            valid <= 1'b1;
        end else begin
            valid <= 1'b0;
        end
    end

    // Unclocked output gate.
    assign drive = ~oe_n;
    assign rdata = oe_n ? '0 : q;
endmodule

// File: rtl/dual_addr_sram.sv
// Module: dual-address synchronous SRAM with pass-through forwarding.
// Two ports, each with registered inputs. The array access and the output
// register load happen one edge after capture. The first edge after reset
// release is ignored.
// Assumes: the output enables are the only unclocked inputs.
module dual_addr_sram
    import dsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         x_addr,
    input  logic [LANE_W*LANES-1:0]   x_wdata,
    input  logic                      x_en_n,
    input  logic                      x_en,
    input  logic                      x_wr_n,
    input  logic                      x_pass_n,
    input  logic                      x_oe_n,
    output logic [LANE_W*LANES-1:0]   x_rdata,
    output logic                      x_drive,
    output logic                      x_valid,
    input  logic [ADDR_W-1:0]         y_addr,
    input  logic [LANE_W*LANES-1:0]   y_wdata,
    input  logic                      y_en_n,
    input  logic                      y_en,
    input  logic                      y_wr_n,
    input  logic                      y_pass_n,
    input  logic                      y_oe_n,
    output logic [LANE_W*LANES-1:0]   y_rdata,
    output logic                      y_drive,
    output logic                      y_valid
);
    localparam int DATA_W = LANE_W * LANES;

    logic              armed;
    port_op_t          x_op, y_op;
    logic [ADDR_W-1:0] x_addr_q, y_addr_q;
    logic [DATA_W-1:0] x_wd_q, y_wd_q;
    logic [DATA_W-1:0] x_arr, y_arr;

    // Start-up qualifier: low through reset and through the first edge after it.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    dsram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in_x (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .addr_i(x_addr), .wdata_i(x_wdata), .en_n_i(x_en_n), .en_i(x_en),
        .wr_n_i(x_wr_n), .pass_n_i(x_pass_n),
        .op_o(x_op), .addr_o(x_addr_q), .wdata_o(x_wd_q)
    );

    dsram_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in_y (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .addr_i(y_addr), .wdata_i(y_wdata), .en_n_i(y_en_n), .en_i(y_en),
        .wr_n_i(y_wr_n), .pass_n_i(y_pass_n),
        .op_o(y_op), .addr_o(y_addr_q), .wdata_o(y_wd_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk(clk),
            .x_we(x_op.wr), .x_addr(x_addr_q), .x_wd(x_wd_q[g*LANE_W +: LANE_W]),
            .y_we(y_op.wr), .y_addr(y_addr_q), .y_wd(y_wd_q[g*LANE_W +: LANE_W]),
            .x_rd(x_arr[g*LANE_W +: LANE_W]), .y_rd(y_arr[g*LANE_W +: LANE_W])
        );
    end

    dsram_out_stage #(.DATA_W(DATA_W)) u_out_x (
        .clk(clk), .rst_n(rst_n),
        .rd_en(x_op.rd), .rd_data(x_arr),
        .fwd_en(y_op.fwd), .fwd_data(y_wd_q),
        .oe_n(x_oe_n), .rdata(x_rdata), .drive(x_drive), .valid(x_valid)
    );

    dsram_out_stage #(.DATA_W(DATA_W)) u_out_y (
        .clk(clk), .rst_n(rst_n),
        .rd_en(y_op.rd), .rd_data(y_arr),
        .fwd_en(x_op.fwd), .fwd_data(x_wd_q),
        .oe_n(y_oe_n), .rdata(y_rdata), .drive(y_drive), .valid(y_valid)
    );
endmodule

// File: rtl/dual_addr_sram_chk.sv
// Module: port-level checker for dual_addr_sram, attached with bind.
// Keeps its own count of edges since reset release, saturating at 3.
// Assumes: the port names and timing of the top module.
module dual_addr_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] x_wdata,
    input logic              x_en_n,
    input logic              x_en,
    input logic              x_pass_n,
    input logic              x_oe_n,
    input logic [DATA_W-1:0] x_rdata,
    input logic              x_drive,
    input logic              x_valid,
    input logic [DATA_W-1:0] y_wdata,
    input logic              y_en_n,
    input logic              y_en,
    input logic              y_pass_n,
    input logic              y_oe_n,
    input logic [DATA_W-1:0] y_rdata,
    input logic              y_drive,
    input logic              y_valid
);
    logic [1:0] seen;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!x_valid && !y_valid));

    assert_first_edge_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd3) |-> (!x_valid && !y_valid));

    assert_x_valid_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && x_valid) |->
            ((!$past(x_en_n, 2) && $past(x_en, 2)) ||
             (!$past(y_en_n, 2) && $past(y_en, 2) && !$past(y_pass_n, 2))));

    assert_y_valid_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && y_valid) |->
            ((!$past(y_en_n, 2) && $past(y_en, 2)) ||
             (!$past(x_en_n, 2) && $past(x_en, 2) && !$past(x_pass_n, 2))));

    assert_pass_x_to_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && !y_oe_n &&
         $past(!x_pass_n && !x_en_n && x_en, 2)) |->
            (y_valid && y_rdata == $past(x_wdata, 2)));

    assert_pass_y_to_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && !x_oe_n &&
         $past(!y_pass_n && !y_en_n && y_en, 2)) |->
            (x_valid && x_rdata == $past(y_wdata, 2)));

    // R3: a disabled port neither drives nor shows data.
    always_comb begin
        assert_x_quiet_R3: assert (!(x_oe_n && (x_drive || x_rdata != '0)));
        assert_y_quiet_R3: assert (!(y_oe_n && (y_drive || y_rdata != '0)));
    end
endmodule

bind dual_addr_sram dual_addr_sram_chk #(.DATA_W(LANE_W*LANES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .x_wdata(x_wdata), .x_en_n(x_en_n), .x_en(x_en), .x_pass_n(x_pass_n),
    .x_oe_n(x_oe_n), .x_rdata(x_rdata), .x_drive(x_drive), .x_valid(x_valid),
    .y_wdata(y_wdata), .y_en_n(y_en_n), .y_en(y_en), .y_pass_n(y_pass_n),
    .y_oe_n(y_oe_n), .y_rdata(y_rdata), .y_drive(y_drive), .y_valid(y_valid)
);

// File: tb/dual_addr_sram_bench.sv
// Directed bench for dual_addr_sram: one task per scenario.
// Inputs change on falling edges, and outputs are sampled on falling edges.
module dual_addr_sram_bench;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic [DW-1:0] x_wdata = '0, y_wdata = '0;
    logic          x_en_n = 1'b1, x_en = 1'b0, x_wr_n = 1'b1, x_pass_n = 1'b1, x_oe_n = 1'b0;
    logic          y_en_n = 1'b1, y_en = 1'b0, y_wr_n = 1'b1, y_pass_n = 1'b1, y_oe_n = 1'b0;
    logic [DW-1:0] x_rdata, y_rdata;
    logic          x_drive, x_valid, y_drive, y_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_addr_sram #(.ADDR_W(AW)) u_dual_addr_sram (
        .clk(clk), .rst_n(rst_n),
        .x_addr(x_addr), .x_wdata(x_wdata), .x_en_n(x_en_n), .x_en(x_en),
        .x_wr_n(x_wr_n), .x_pass_n(x_pass_n), .x_oe_n(x_oe_n),
        .x_rdata(x_rdata), .x_drive(x_drive), .x_valid(x_valid),
        .y_addr(y_addr), .y_wdata(y_wdata), .y_en_n(y_en_n), .y_en(y_en),
        .y_wr_n(y_wr_n), .y_pass_n(y_pass_n), .y_oe_n(y_oe_n),
        .y_rdata(y_rdata), .y_drive(y_drive), .y_valid(y_valid)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        x_en_n = 1'b1; x_en = 1'b0; x_wr_n = 1'b1; x_pass_n = 1'b1;
        y_en_n = 1'b1; y_en = 1'b0; y_wr_n = 1'b1; y_pass_n = 1'b1;
    endtask

    task automatic set_x(input logic en_n, input logic en, input logic wr_n, input logic pass_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        x_en_n = en_n; x_en = en; x_wr_n = wr_n; x_pass_n = pass_n; x_addr = a; x_wdata = d;
    endtask

    task automatic set_y(input logic en_n, input logic en, input logic wr_n, input logic pass_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        y_en_n = en_n; y_en = en; y_wr_n = wr_n; y_pass_n = pass_n; y_addr = a; y_wdata = d;
    endtask

    // Capture edge, then load edge; returns at the falling edge after the load.
    task automatic finish_op();
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    task automatic wr_x(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_x(1'b0, 1'b1, 1'b0, 1'b1, a, d);
        finish_op();
    endtask

    task automatic rd_both(input logic [AW-1:0] ax, input logic [AW-1:0] ay);
        set_x(1'b0, 1'b1, 1'b1, 1'b1, ax, '0);
        set_y(1'b0, 1'b1, 1'b1, 1'b1, ay, '0);
        finish_op();
    endtask

    task automatic test_reset();
        rst_n = 1'b0; idle();
        @(negedge clk); @(negedge clk);
        chk("R10 x_valid in reset", DW'(x_valid), 0);
        chk("R10 y_valid in reset", DW'(y_valid), 0);
        chk("R10 x_rdata in reset", x_rdata, 0);
        chk("R10 y_rdata in reset", y_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_write_read();
        wr_x(6'd3, 36'h9ABCDEF01);
        set_y(1'b0, 1'b1, 1'b0, 1'b1, 6'd10, 36'h123456789);
        finish_op();
        set_x(1'b0, 1'b1, 1'b1, 1'b1, 6'd10, '0);
        set_y(1'b0, 1'b1, 1'b1, 1'b1, 6'd3, '0);
        @(negedge clk);
        idle();
        chk("R1 x_valid after capture edge only", DW'(x_valid), 0);
        @(negedge clk);
        chk("R1 x reads word written by y", x_rdata, 36'h123456789);
        chk("R1 y reads word written by x", y_rdata, 36'h9ABCDEF01);
        chk("R1 x_valid after load edge", DW'(x_valid), 1);
    endtask

    task automatic test_oe();
        x_oe_n = 1'b1; #1;
        chk("R3 x_drive off", DW'(x_drive), 0);
        chk("R3 x_rdata zero when off", x_rdata, 0);
        x_oe_n = 1'b0; #1;
        chk("R3 x_drive on", DW'(x_drive), 1);
        chk("R3 x_rdata shows register", x_rdata, 36'h123456789);
        @(negedge clk);
    endtask

    task automatic test_select();
        set_x(1'b1, 1'b1, 1'b0, 1'b1, 6'd3, 36'h0);
        finish_op();
        set_x(1'b0, 1'b0, 1'b0, 1'b1, 6'd3, 36'h0);
        finish_op();
        chk("R2 write cycle leaves x_valid low", DW'(x_valid), 0);
        chk("R2 write cycle holds x output", x_rdata, 36'h123456789);
        set_x(1'b0, 1'b0, 1'b1, 1'b1, 6'd3, '0);
        finish_op();
        chk("R2 deselected read x_valid", DW'(x_valid), 0);
        chk("R2 deselected read holds x output", x_rdata, 36'h123456789);
        rd_both(6'd10, 6'd3);
        chk("R2 deselected writes stored nothing", y_rdata, 36'h9ABCDEF01);
    endtask

    task automatic test_same_read();
        rd_both(6'd3, 6'd3);
        chk("R5 x same-address read", x_rdata, 36'h9ABCDEF01);
        chk("R5 y same-address read", y_rdata, 36'h9ABCDEF01);
    endtask

    task automatic test_read_before_write();
        wr_x(6'd7, 36'h111111111);
        set_x(1'b0, 1'b1, 1'b0, 1'b1, 6'd7, 36'h222222222);
        set_y(1'b0, 1'b1, 1'b1, 1'b1, 6'd7, '0);
        finish_op();
        chk("R6 y reads old word during x write", y_rdata, 36'h111111111);
        rd_both(6'd7, 6'd7);
        chk("R6 new word stored afterwards", x_rdata, 36'h222222222);
    endtask

    task automatic test_both_write();
        set_x(1'b0, 1'b1, 1'b0, 1'b1, 6'd8, 36'h333333333);
        set_y(1'b0, 1'b1, 1'b0, 1'b1, 6'd8, 36'h444444444);
        finish_op();
        rd_both(6'd8, 6'd8);
        chk("R7 y wins double write", x_rdata, 36'h444444444);
    endtask

    task automatic test_pass();
        set_x(1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 36'h5A5A5A5A5);
        set_y(1'b0, 1'b1, 1'b1, 1'b1, 6'd10, '0);
        finish_op();
        chk("R4 y gets x forward over its read", y_rdata, 36'h5A5A5A5A5);
        chk("R4 x still reads array", x_rdata, 36'h9ABCDEF01);
        set_x(1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 36'h0F0F0F0F0);
        set_y(1'b0, 1'b1, 1'b1, 1'b0, 6'd10, 36'hA5A5A5A5A);
        finish_op();
        chk("R4 two-way forward to x", x_rdata, 36'hA5A5A5A5A);
        chk("R4 two-way forward to y", y_rdata, 36'h0F0F0F0F0);
    endtask

    task automatic test_write_while_pass();
        set_x(1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 36'h0F0F0F0F0);
        set_y(1'b0, 1'b1, 1'b0, 1'b1, 6'd9, 36'h999999999);
        finish_op();
        chk("R8 writing y shows forwarded word", y_rdata, 36'h0F0F0F0F0);
        chk("R8 writing y valid", DW'(y_valid), 1);
        rd_both(6'd9, 6'd3);
        chk("R8 y write still stored", x_rdata, 36'h999999999);
    endtask

    task automatic test_first_edge();
        wr_x(6'd5, 36'hBBBBBBBBB);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        set_x(1'b0, 1'b1, 1'b0, 1'b1, 6'd5, 36'hCCCCCCCCC);
        set_y(1'b0, 1'b1, 1'b1, 1'b1, 6'd5, '0);
        finish_op();
        chk("R9 read on first edge gives no valid", DW'(y_valid), 0);
        rd_both(6'd5, 6'd5);
        chk("R9 write on first edge ignored", x_rdata, 36'hBBBBBBBBB);
    endtask

    initial begin
        test_reset();
        test_write_read();
        test_oe();
        test_select();
        test_same_read();
        test_read_before_write();
        test_both_write();
        test_pass();
        test_write_while_pass();
        test_first_edge();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule